// File: doc/BRIEF.md
# Dual-Bank Maskable Interrupt Controller

This controller collects forty level-sensitive interrupt sources and reduces them to three request lines toward a processor core: a normal interrupt request, a fast interrupt request and a wake request. Each source has an enable bit and a steering bit. The enable bit gates the source. The steering bit sends an enabled source either to the fast line or to the normal line. Per-source state is held in two 32-bit banks. Sources 0 to 31 sit in the first bank at their own bit position. Sources 32 to 39 sit in the second bank at bit position (n - 32).

Software reaches the controller through a plain 32-bit register port with a byte address, a write strobe and a combinational read. Through this port it programs the enables, the steering, a wake-policy bit and a table of forty priority entries. It can also read the live pending state in raw and filtered forms. The controller only stores the priority table and exposes it as a packed vector. A separate block resolves the highest-priority source from that vector.

A pending bit is not latched. It copies the source level on every clock edge. The wake request works only while the core reports it is halted. A control bit chooses whether the wake request respects the enables or reacts to any pending source.

Top module: `dual_bank_intc`

## Requirements
- R1: A source n below 32 uses bit n of the first-bank registers, and a source n of 32 or more uses bit n-32 of the second-bank registers. Second-bank enable (0xA0) and steering (0xA4) read bits 31:8 as zero, and writes to those bits are discarded.
- R2: Raw pending reads (0x10 first bank, 0xAC second bank) return the source levels sampled at the previous clock edge. A source that goes low clears its bit. Writes to these offsets change nothing.
- R3: `fiq_o` and `irq_o` are registered. At each clock edge, `fiq_o` takes the OR over all sources of (level AND enable AND steer), and `irq_o` takes the OR of (level AND enable AND NOT steer). Both use the source levels at that edge and the register contents held before it.
- R4: Enable registers (0x04, 0xA0) use 1 = enabled. Steering registers (0x08, 0xA4) use 1 = fast line and 0 = normal line. Both read back as written.
- R5: Filtered reads return pending AND enable AND NOT steer at 0x00 and 0x9C, and pending AND enable AND steer at 0x0C and 0xA8.
- R6: The control register at 0x14 keeps only bit 0 and reads 0 in bits 31:1.
- R7: `wake_o` is registered. It is set when `halted_i` is high and some source is high, counting only enabled sources when control bit 0 is 1 and all sources when it is 0. It is low while `halted_i` is low.
- R8: Priority entry i is at 0x1C+4i for i < 32 and at 0xB0+4(i-32) for i >= 32. A write keeps bit 31 and bits 5:0, and the other bits read as zero. `prio_tbl_o[7i+6:7i]` carries entry i as {bit 31, bits 5:0}.
- R9: Reset clears enables, steering, pending, the priority table and all three outputs, and sets control bit 0 to 1.
- R10: Any other offset, including 0x18, unaligned addresses and offsets above 0xCC, reads as zero, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 40 | Source levels, 1 = requesting |
| halted_i | input | 1 | Core is halted; enables the wake request |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake request while halted |
| prio_tbl_o | output | 280 | Packed priority table, 7 bits per entry |

## Verification
Some properties are checked by assertions on every cycle. Both request lines stay low after a cycle with no source high or with every enable clear. The wake line stays low unless the core was halted. Raw pending reads echo the previous cycle's levels. Zero fields read as zero in the control register, the second-bank registers, the priority entries and the 0x18 hole. Other behaviour needs the bench's scenarios: the exact steering split between the two lines, the choice between the two wake policies, bank indexing for sources 32 to 39, how priority writes are truncated, and the fact that writes to undecoded or read-only offsets leave no trace. A full address sweep and a long random phase exercise these, and every cycle is compared against a behavioural model.

// File: rtl/dual_bank_intc.sv
module dual_bank_intc #(
  parameter int NSRC = 40,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              halted_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              wake_o,
  output logic [NSRC*7-1:0] prio_tbl_o
);
  localparam int HI = NSRC - 32;
  localparam int IW = $clog2(NSRC);

  logic [NSRC-1:0] pend_q, mask_q, steer_q;
  logic            ctrl_q, armed_q;
  logic [6:0]      prio_q [NSRC];

  logic [AW-1:0] off_lo, off_hi;
  logic          lo_hit, hi_hit, prio_hit;
  logic [IW-1:0] prio_idx;

  assign off_lo   = addr_i - AW'(8'h1C);
  assign off_hi   = addr_i - AW'(8'hB0);
  assign lo_hit   = addr_i >= AW'(8'h1C) && addr_i <= AW'(8'h98) && addr_i[1:0] == 2'b00;
  assign hi_hit   = addr_i >= AW'(8'hB0) && addr_i <= AW'(8'hB0 + 4*(HI-1)) && addr_i[1:0] == 2'b00;
  assign prio_hit = lo_hit || hi_hit;
  assign prio_idx = lo_hit ? IW'(off_lo[AW-1:2]) : IW'(32 + int'(off_hi[4:2]));

  function automatic logic [DW-1:0] bank(input logic [NSRC-1:0] v, input logic sel);
    return sel ? DW'(v[NSRC-1:32]) : v[31:0];
  endfunction

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(8'h00): rdata_o = bank(pend_q & mask_q & ~steer_q, 1'b0);
      AW'(8'h04): rdata_o = bank(mask_q, 1'b0);
      AW'(8'h08): rdata_o = bank(steer_q, 1'b0);
      AW'(8'h0C): rdata_o = bank(pend_q & mask_q & steer_q, 1'b0);
      AW'(8'h10): rdata_o = bank(pend_q, 1'b0);
      AW'(8'h14): rdata_o = DW'(ctrl_q);
      AW'(8'h9C): rdata_o = bank(pend_q & mask_q & ~steer_q, 1'b1);
      AW'(8'hA0): rdata_o = bank(mask_q, 1'b1);
      AW'(8'hA4): rdata_o = bank(steer_q, 1'b1);
      AW'(8'hA8): rdata_o = bank(pend_q & mask_q & steer_q, 1'b1);
      AW'(8'hAC): rdata_o = bank(pend_q, 1'b1);
      default: if (prio_hit)
                 rdata_o = {prio_q[prio_idx][6], {(DW-7){1'b0}}, prio_q[prio_idx][5:0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= '0;
      steer_q <= '0;
      ctrl_q  <= 1'b1;
      armed_q <= 1'b0;
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
      wake_o  <= 1'b0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
    end else begin
      armed_q <= 1'b1;
      pend_q  <= src_i;
      irq_o   <= |(src_i & mask_q & ~steer_q);
      fiq_o   <= |(src_i & mask_q & steer_q);
      wake_o  <= halted_i && |(src_i & (ctrl_q ? mask_q : {NSRC{1'b1}}));
      if (we_i) begin
        case (addr_i)
          AW'(8'h04): mask_q[31:0]       <= wdata_i;
          AW'(8'h08): steer_q[31:0]      <= wdata_i;
          AW'(8'h14): ctrl_q             <= wdata_i[0];
          AW'(8'hA0): mask_q[NSRC-1:32]  <= wdata_i[HI-1:0];
          AW'(8'hA4): steer_q[NSRC-1:32] <= wdata_i[HI-1:0];
          default: if (prio_hit) prio_q[prio_idx] <= {wdata_i[DW-1], wdata_i[5:0]};
        endcase
      end
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_tbl
    assign prio_tbl_o[7*g +: 7] = prio_q[g];
  end

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(src_i) == '0 |-> !irq_o && !fiq_o);
  p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_q) == '0 |-> !irq_o && !fiq_o);
  p_wake_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(halted_i) |-> !wake_o);
  p_raw_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && addr_i == AW'(8'h10) |-> rdata_o == $past(src_i[31:0]));
  p_bank2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == AW'(8'hA0) || addr_i == AW'(8'hA4)) |-> rdata_o[DW-1:HI] == '0);
  p_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_i == AW'(8'h14) |-> rdata_o[DW-1:1] == '0);
  p_prio_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_i >= AW'(8'h1C) && addr_i <= AW'(8'h98) |-> rdata_o[DW-2:6] == '0);
  p_hole_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_i == AW'(8'h18) |-> rdata_o == '0);
endmodule

// File: tb/dual_bank_intc_bench.sv
module dual_bank_intc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 40;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0;
  logic halted = 0, we = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, fiq, wake;
  logic [N*7-1:0] tbl;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_intc u_dual_bank_intc (
    .clk(clk), .rst_n(rst_n), .src_i(src), .halted_i(halted), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .fiq_o(fiq), .wake_o(wake), .prio_tbl_o(tbl));

  // behavioural reference model
  logic [63:0] m_pend, m_en, m_fq;
  logic m_ctrl, m_irq, m_fiq, m_wake;
  logic [31:0] m_prio [N];

  function automatic logic [7:0] prio_addr(int i);
    return (i < 32) ? 8'(28 + 4*i) : 8'(176 + 4*(i-32));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= 0; m_en <= 0; m_fq <= 0; m_ctrl <= 1;
      m_irq <= 0; m_fiq <= 0; m_wake <= 0;
      for (int i = 0; i < N; i++) m_prio[i] <= 0;
    end else begin
      bit any_f, any_i, any_w;
      any_f = 0; any_i = 0; any_w = 0;
      for (int i = 0; i < N; i++) if (src[i]) begin
        if (m_en[i] && m_fq[i]) any_f = 1;
        if (m_en[i] && !m_fq[i]) any_i = 1;
        if (!m_ctrl || m_en[i]) any_w = 1;
      end
      m_fiq <= any_f; m_irq <= any_i; m_wake <= halted && any_w;
      m_pend <= 64'(src);
      if (we) begin
        case (addr)
          8'h04: m_en[31:0] <= wdata;
          8'h08: m_fq[31:0] <= wdata;
          8'hA0: m_en[63:32] <= {24'h0, wdata[7:0]};
          8'hA4: m_fq[63:32] <= {24'h0, wdata[7:0]};
          8'h14: m_ctrl <= wdata[0];
          default: for (int i = 0; i < N; i++)
                     if (addr == prio_addr(i)) m_prio[i] <= wdata & 32'h8000_003F;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    logic [63:0] ip, fp;
    ip = m_pend & m_en & ~m_fq;
    fp = m_pend & m_en & m_fq;
    case (a)
      8'h00: return ip[31:0];   8'h9C: return ip[63:32];
      8'h0C: return fp[31:0];   8'hA8: return fp[63:32];
      8'h04: return m_en[31:0]; 8'hA0: return m_en[63:32];
      8'h08: return m_fq[31:0]; 8'hA4: return m_fq[63:32];
      8'h10: return m_pend[31:0]; 8'hAC: return m_pend[63:32];
      8'h14: return {31'h0, m_ctrl};
      default: for (int i = 0; i < N; i++) if (a == prio_addr(i)) return m_prio[i];
    endcase
    return 0;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00, 8'h9C, 8'h0C, 8'hA8: return "R5";
      8'h04, 8'h08: return "R4";
      8'hA0, 8'hA4: return "R1";
      8'h10, 8'hAC: return "R2";
      8'h14: return "R6";
      default: for (int i = 0; i < N; i++) if (a == prio_addr(i)) return "R8";
    endcase
    return "R10";
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the edge
  initial forever begin
    @(posedge clk); #1;
    if (rst_n) begin
      chk("R3", "fiq_o", 32'(fiq), 32'(m_fiq));
      chk("R3", "irq_o", 32'(irq), 32'(m_irq));
      chk("R7", "wake_o", 32'(wake), 32'(m_wake));
      chk(tag_of(addr), $sformatf("rdata @%h", addr), rdata, exp_rd(addr));
      for (int i = 0; i < N; i++)
        chk("R8", $sformatf("table entry %0d", i), 32'(tbl[7*i +: 7]),
            {25'h0, m_prio[i][31], m_prio[i][5:0]});
    end
  end

  task automatic step(logic w, logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = w; addr = a; wdata = d;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    addr = 8'h14;
    #(CLK_PERIOD*3);
    chk("R9", "control at reset", rdata, 32'h1);
    chk("R9", "outputs at reset", {29'h0, irq, fiq, wake}, 0);
    chk("R9", "table at reset", 32'(|tbl), 0);
    @(negedge clk); rst_n = 1;

    // steering split in the first bank
    step(1, 8'h04, 32'h0000_00F0);
    step(1, 8'h08, 32'h0000_0030);
    step(0, 8'h00, 0); src = 40'h00_0000_00FF;
    step(0, 8'h0C, 0); step(0, 8'h10, 0); step(0, 8'h00, 0);
    src = 40'h00_0000_0030; step(0, 8'h00, 0); step(0, 8'h0C, 0);
    // second bank
    step(1, 8'hA0, 32'hFFFF_FF81);
    step(1, 8'hA4, 32'hFFFF_FF80);
    src = 40'h80_0000_0000; step(0, 8'hA8, 0); step(0, 8'hAC, 0);
    src = 40'h01_0000_0000; step(0, 8'h9C, 0); step(0, 8'hA0, 0); step(0, 8'hA4, 0);
    // wake policies
    halted = 1; src = 40'h02_0000_0000; step(0, 8'h14, 0); step(0, 8'h14, 0);
    step(1, 8'h14, 32'hFFFF_FFFE); step(0, 8'h14, 0); step(0, 8'h14, 0);
    src = 0; step(0, 8'h14, 0); halted = 0; src = 40'hFF_FFFF_FFFF;
    step(1, 8'h14, 32'h1); step(0, 8'h14, 0);
    // priority table
    for (int i = 0; i < N; i++) step(1, prio_addr(i), 32'hFFFF_FF00 ^ (32'(i) * 32'h0101_0107));
    // writes to undecoded or read-only offsets
    foreach (wdata[k]) ;
    step(1, 8'h18, '1); step(1, 8'h00, '1); step(1, 8'h10, '1); step(1, 8'hAC, '1);
    step(1, 8'h1D, '1); step(1, 8'hD0, '1); step(1, 8'hFC, '1); step(1, 8'h9C, '1);
    src = 40'h5A_A5A5_5A5A;
    for (int a = 0; a < 256; a++) step(0, 8'(a), 0);
    // random phase
    for (int c = 0; c < 3000; c++) begin
      logic [7:0] a;
      a = ($urandom % 2) ? 8'($urandom) : 8'(4 * ($urandom % 52));
      if ($urandom % 4 == 0) src = 40'({$urandom, $urandom} & {$urandom, $urandom});
      if ($urandom % 16 == 0) halted = ~halted;
      step(($urandom % 3) == 0, a, $urandom);
    end
    step(0, 8'h00, 0); step(0, 8'h00, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule